// File: doc/BRIEF.md
# Sweep-Synchronised Capture Tick Generator

This block sits beside a waveform table player and gives an external capture unit a timing mark tied to the sweep cycle. It watches two status signals from the player: a level that is high while a sweep is running, and a one-cycle pulse that marks the end of a sweep. It also watches the strobe that marks each new output sample.

Each end-of-sweep pulse restarts a delay timer. The timer counts I/Q sample pairs, where one pair is two sample strobes. When the programmed number of pairs has elapsed, the block emits a one-cycle capture tick and stops counting until the next end-of-sweep pulse. The delay is normally set so that the tick lands about a fifth of the way into the sweep that follows. With the tick, the block latches a validity flag. The flag says whether that next sweep was already running when the tick fired, so the capture can be trusted to fall inside a sweep. The flag keeps its value until the next tick.

Top module: `sweep_capture_tick`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `cap_tick` and `cap_valid` are 0. After reset the timer is idle.
- R2: `cap_tick` is high for exactly one cycle. That cycle follows the clock edge that samples the 2*SAMPLE_DELAY-th `sample_stb` counted after the most recent `sweep_done`.
- R3: While the timer is idle (after reset, or after a tick, with no `sweep_done` since), `sample_stb` pulses produce no tick.
- R4: A `sweep_done` restarts the count from zero. A `sample_stb` in the same cycle as `sweep_done` is not counted.
- R5: If a second `sweep_done` arrives before the delay expires, no tick is issued for the earlier sweep. The tick follows 2*SAMPLE_DELAY strobes after the later pulse.
- R6: In the cycle `cap_tick` is high, `cap_valid` equals the value `sweep_busy` had on the edge that produced the tick (1 = the next sweep had started).
- R7: `cap_valid` changes only together with a tick, or with reset. Changes of `sweep_busy` in between have no effect on it.
- R8: Each `sweep_done` yields at most one tick. Strobes after the tick produce no further tick until the next `sweep_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sweep_busy | input | 1 | High while a sweep is running |
| sweep_done | input | 1 | One-cycle pulse at the end of a sweep |
| sample_stb | input | 1 | One-cycle strobe per output sample |
| cap_tick | output | 1 | One-cycle capture tick, registered |
| cap_valid | output | 1 | Sweep was running at the last tick, registered |

## Verification
Both outputs are registered. They are due one cycle after the edge that samples the completing strobe, so the tick and its validity flag become visible together. The bench sets inputs at the falling edge and steps one rising edge. It then reads the outputs at the next falling edge, so each sample shows exactly the result of the strobe just applied. Checks sit after every strobe and every idle cycle, which confirms that the tick appears at the 2*SAMPLE_DELAY-th strobe and at no earlier or later one. It also confirms that the tick has vanished one cycle later.

// File: rtl/sct_pkg.sv
package sct_pkg;
  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } pair_phase_e;
endpackage

// File: rtl/sct_pair_timer.sv
module sct_pair_timer
  import sct_pkg::*;
#(
  parameter int SAMPLE_DELAY = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic stb,
  output logic expire
);
  localparam int CNT_W = (SAMPLE_DELAY > 1) ? $clog2(SAMPLE_DELAY) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SAMPLE_DELAY - 1);

  logic             armed;
  logic [CNT_W-1:0] cnt;
  pair_phase_e      phase;

  assign expire = armed && stb && !restart &&
                  (phase == PH_SECOND) && (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
      phase <= PH_FIRST;
    end else if (restart) begin
      armed <= 1'b1;
      cnt   <= '0;
      phase <= PH_FIRST;
    end else if (armed && stb) begin
      if (phase == PH_FIRST) begin
        phase <= PH_SECOND;
      end else begin
        phase <= PH_FIRST;
        if (cnt == LAST_CNT) begin
          armed <= 1'b0;
          cnt   <= '0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R4
  restart_no_expire_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> !expire);
  // R8
  expire_disarms_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> !armed);
  // R3
  idle_no_expire_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !expire);
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_CNT);
endmodule

// File: rtl/sct_tick_reg.sv
module sct_tick_reg (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic busy,
  output logic tick,
  output logic valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tick  <= 1'b0;
      valid <= 1'b0;
    end else begin
      tick <= expire;
      if (expire) valid <= busy;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!tick && !valid));
  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R6
  valid_follows_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tick) |-> (valid == $past(busy)));
  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |-> $stable(valid));
endmodule

// File: rtl/sweep_capture_tick.sv
module sweep_capture_tick #(
  parameter int SAMPLE_DELAY = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic sweep_busy,
  input  logic sweep_done,
  input  logic sample_stb,
  output logic cap_tick,
  output logic cap_valid
);
  logic expire;

  sct_pair_timer #(.SAMPLE_DELAY(SAMPLE_DELAY)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (sweep_done),
    .stb     (sample_stb),
    .expire  (expire)
  );

  sct_tick_reg u_tick (
    .clk    (clk),
    .rst    (rst),
    .expire (expire),
    .busy   (sweep_busy),
    .tick   (cap_tick),
    .valid  (cap_valid)
  );
endmodule

// File: tb/sweep_capture_tick_bench.sv
module sweep_capture_tick_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PAIRS = 3;
  localparam int STROBES = 2 * PAIRS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sweep_busy = 1'b0;
  logic sweep_done = 1'b0;
  logic sample_stb = 1'b0;
  logic cap_tick, cap_valid;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sweep_capture_tick #(.SAMPLE_DELAY(PAIRS)) u_sweep_capture_tick (
    .clk(clk), .rst(rst), .sweep_busy(sweep_busy), .sweep_done(sweep_done),
    .sample_stb(sample_stb), .cap_tick(cap_tick), .cap_valid(cap_valid)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one clock: inputs set at falling edge, outputs read at the next one
  task automatic cyc(input logic d, input logic s);
    sweep_done = d;
    sample_stb = s;
    @(posedge clk);
    @(negedge clk);
    sweep_done = 1'b0;
    sample_stb = 1'b0;
  endtask

  task automatic strobes(input int n, input bit tick_last, input bit gaps,
                         input string tag);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 1'b1);
      chk(cap_tick, (i == n - 1) && tick_last, tag);
      if (gaps) begin
        cyc(1'b0, 1'b0);
        chk(cap_tick, 1'b0, tag);
      end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    sample_stb = 1'b1;
    sweep_done = 1'b1;
    repeat (3) @(negedge clk);
    chk(cap_tick, 1'b0, "R1 tick in reset");
    chk(cap_valid, 1'b0, "R1 valid in reset");
    sample_stb = 1'b0;
    sweep_done = 1'b0;
    rst = 1'b0;
    cyc(1'b0, 1'b0);
    chk(cap_tick, 1'b0, "R1 tick after reset");
    chk(cap_valid, 1'b0, "R1 valid after reset");
  endtask

  task automatic t_idle;
    strobes(3 * STROBES, 1'b0, 1'b0, "R3 idle strobes");
  endtask

  task automatic t_basic;
    sweep_busy = 1'b1;
    cyc(1'b1, 1'b0);
    chk(cap_tick, 1'b0, "R2 no tick at done");
    strobes(STROBES, 1'b1, 1'b1, "R2 tick at last pair");
    chk(cap_valid, 1'b1, "R6 valid with busy");
    sweep_busy = 1'b0;
    strobes(STROBES + 2, 1'b0, 1'b1, "R8 no second tick");
    chk(cap_valid, 1'b1, "R7 valid held while busy low");
  endtask

  task automatic t_invalid;
    sweep_busy = 1'b0;
    cyc(1'b1, 1'b0);
    strobes(STROBES, 1'b1, 1'b0, "R2 back-to-back strobes");
    chk(cap_valid, 1'b0, "R6 valid cleared without sweep");
    sweep_busy = 1'b1;
    strobes(2, 1'b0, 1'b0, "R8 idle after tick");
    chk(cap_valid, 1'b0, "R7 valid held while busy high");
  endtask

  task automatic t_same_cycle;
    sweep_busy = 1'b1;
    cyc(1'b1, 1'b1);
    chk(cap_tick, 1'b0, "R4 done with strobe");
    strobes(STROBES, 1'b1, 1'b1, "R4 strobe at done not counted");
    chk(cap_valid, 1'b1, "R6 valid set again");
  endtask

  task automatic t_retrigger;
    sweep_busy = 1'b0;
    cyc(1'b1, 1'b0);
    strobes(STROBES - 1, 1'b0, 1'b0, "R5 first sweep partial");
    cyc(1'b1, 1'b0);
    chk(cap_tick, 1'b0, "R5 restart");
    strobes(STROBES - 1, 1'b0, 1'b1, "R5 old count dropped");
    sweep_busy = 1'b1;
    strobes(1, 1'b1, 1'b0, "R5 tick after later done");
    chk(cap_valid, 1'b1, "R6 valid after retrigger");
  endtask

  initial begin
    t_reset;
    t_idle;
    t_basic;
    t_invalid;
    t_same_cycle;
    t_retrigger;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule